// File: doc/BRIEF.md
# Sobel Gradient Magnitude Pipeline

This block turns a stream of pixel columns into edge-strength values. Each accepted input carries three vertically adjacent pixels (top, middle, bottom). The block slides them into a three-column window and computes the horizontal and vertical Sobel sums together in one stage. A second stage turns those sums into a saturated gradient magnitude, and a third stage presents the magnitude on a write port for a result cache. A write strobe qualifies the port, and an index gives the result's position within the row.

A column flagged as end-of-row or end-of-frame closes the row. That column still completes its own window, and the results already in flight drain normally. The window then starts empty, so the next row's first two columns produce no output. The producer of the columns and the frame store behind the write port are not part of this block.

Top module: `sobel_pipe`

## Requirements
- R1: While reset is asserted, and right after it, `res_we` is 0 and `res_pix` and `res_idx` are 0.
- R2: A cycle with `col_valid` low leaves the window unchanged. The data on the column inputs in that cycle has no effect on any later result.
- R3: The window holds the last three accepted columns, with column 0 the oldest. Dx is (top + 2·middle + bottom) of the newest column minus the same sum for the oldest column. Dy is (oldest + 2·centre + newest) of the bottom row minus the same sum for the top row.
- R4: The result pixel is |Dx| + |Dy|, clamped to 255 for the default 8-bit pixel.
- R5: A result appears on the write port (`res_we` high) exactly three clock cycles after the clock edge that accepted the column completing its window.
- R6: After reset or a row flush, the first two accepted columns produce no result. The third accepted column produces the first result of the row.
- R7: A column with `col_row_end` or `col_frame_end` set is the last column of its row. It still yields its own result if its window is full, and the window is empty again for the next accepted column.
- R8: `res_idx` is 0 for the first result of a row and increases by one for each further result of that row. After the row's last result it starts again at 0.
- R9: The three stages overlap. Consecutive valid columns in a filled window give one result per cycle with no gap.
- R10: `res_we` is low in every cycle that does not carry a result as defined above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | Column inputs carry a column this cycle |
| col_top | input | 8 | Upper pixel of the column |
| col_mid | input | 8 | Middle pixel of the column |
| col_bot | input | 8 | Lower pixel of the column |
| col_row_end | input | 1 | This column ends the row |
| col_frame_end | input | 1 | This column ends the frame (and its row) |
| res_we | output | 1 | Write strobe for the result cache |
| res_pix | output | 8 | Gradient magnitude to write |
| res_idx | output | 10 | Position of the result within its row |

## Verification
The hard collision is a row's drain and the next row's refill happening at the same time. For three cycles after a flush column, the previous row's last results are still leaving through stages two and three. In the same cycles the new row's first columns are entering an emptied window, and the write index must return to 0 exactly between the two rows. The bench provokes this by sending a row closed by end-of-frame, followed at once by another row with no idle cycle. A behavioural model predicts the strobe, pixel and index for every cycle, so any result lost, duplicated or mis-indexed at the seam shows up.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
   // How the two gradient components are merged into one strength value.
   typedef enum logic [0:0] {
      MAG_SUM_ABS = 1'b0,   // |dx| + |dy|
      MAG_MAX_ABS = 1'b1    // max(|dx|, |dy|)
   } mag_mode_e;

   // Signed width that holds a 1-2-1 weighted difference of pixels.
   function automatic int unsigned grad_width(input int unsigned pix_w);
      return pix_w + 3;
   endfunction
endpackage

// File: rtl/sobel_window.sv
module sobel_window #(
   parameter int unsigned PIX_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_v,
   input  logic                          in_flush,
   input  logic [PIX_W-1:0]              in_top,
   input  logic [PIX_W-1:0]              in_mid,
   input  logic [PIX_W-1:0]              in_bot,
   output logic [2:0][2:0][PIX_W-1:0]    win,      // [column][row], column 0 oldest, row 0 top
   output logic                          win_v,
   output logic                          win_last
);
   logic [1:0] fill;   // columns held since the last flush, saturating at 3

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win      <= '0;
         win_v    <= 1'b0;
         win_last <= 1'b0;
         fill     <= 2'd0;
      end else begin
         win_v    <= 1'b0;
         win_last <= 1'b0;
         if (in_v) begin
            for (int c = 0; c < 2; c++) win[c] <= win[c+1];
            win[2]   <= {in_bot, in_mid, in_top};
            win_v    <= (fill >= 2'd2);
            win_last <= in_flush;
            if (in_flush)            fill <= 2'd0;
            else if (fill != 2'd3)   fill <= fill + 2'd1;
         end
      end
   end

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && in_flush) |=> (fill == 2'd0));

   p_blank_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && fill < 2'd2) |=> !win_v);

   p_idle_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_v |=> ($stable(win) && !win_v));
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad #(
   parameter int unsigned PIX_W = 8,
   localparam int unsigned GW   = sobel_pkg::grad_width(PIX_W)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [2:0][2:0][PIX_W-1:0]    win,
   input  logic                          in_v,
   input  logic                          in_last,
   output logic signed [GW-1:0]          dx,
   output logic signed [GW-1:0]          dy,
   output logic                          out_v,
   output logic                          out_last
);
   localparam logic signed [GW-1:0] LIM = GW'(4 * ((1 << PIX_W) - 1));

   function automatic logic signed [GW-1:0] wsum(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b,
                                                 input logic [PIX_W-1:0] c);
      return $signed({3'b000, a}) + $signed({2'b00, b, 1'b0}) + $signed({3'b000, c});
   endfunction

   logic signed [GW-1:0] dx_c, dy_c;
   always_comb begin
      dx_c = wsum(win[2][0], win[2][1], win[2][2]) - wsum(win[0][0], win[0][1], win[0][2]);
      dy_c = wsum(win[0][2], win[1][2], win[2][2]) - wsum(win[0][0], win[1][0], win[2][0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dx <= '0; dy <= '0; out_v <= 1'b0; out_last <= 1'b0;
      end else begin
         dx       <= dx_c;
         dy       <= dy_c;
         out_v    <= in_v;
         out_last <= in_v && in_last;
      end
   end

   p_sum_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |-> (dx <= LIM && dx >= -LIM && dy <= LIM && dy >= -LIM));
endmodule

// File: rtl/sobel_mag.sv
module sobel_mag #(
   parameter int unsigned          PIX_W    = 8,
   parameter sobel_pkg::mag_mode_e MAG_MODE = sobel_pkg::MAG_SUM_ABS,
   localparam int unsigned         GW       = sobel_pkg::grad_width(PIX_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [GW-1:0]    dx,
   input  logic signed [GW-1:0]    dy,
   input  logic                    in_v,
   input  logic                    in_last,
   output logic [PIX_W-1:0]        mag,
   output logic                    out_v,
   output logic                    out_last
);
   localparam logic [GW:0]          CLAMP = {4'b0000, {PIX_W{1'b1}}};
   localparam logic signed [GW-1:0] SAT_S = GW'((1 << PIX_W) - 1);

   logic [GW-1:0] ax, ay;
   logic [GW:0]   merged;

   assign ax = dx[GW-1] ? -dx : dx;
   assign ay = dy[GW-1] ? -dy : dy;

   generate
      if (MAG_MODE == sobel_pkg::MAG_SUM_ABS) begin : g_sum
         assign merged = {1'b0, ax} + {1'b0, ay};
      end else begin : g_max
         assign merged = (ax > ay) ? {1'b0, ax} : {1'b0, ay};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mag <= '0; out_v <= 1'b0; out_last <= 1'b0;
      end else begin
         mag      <= (merged > CLAMP) ? {PIX_W{1'b1}} : merged[PIX_W-1:0];
         out_v    <= in_v;
         out_last <= in_v && in_last;
      end
   end

   p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && (dx >= SAT_S || dx <= -SAT_S)) |=> (mag == {PIX_W{1'b1}}));
endmodule

// File: rtl/sobel_pipe.sv
module sobel_pipe #(
   parameter int unsigned          PIX_W    = 8,
   parameter int unsigned          IDX_W    = 10,
   parameter sobel_pkg::mag_mode_e MAG_MODE = sobel_pkg::MAG_SUM_ABS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_valid,
   input  logic [PIX_W-1:0]  col_top,
   input  logic [PIX_W-1:0]  col_mid,
   input  logic [PIX_W-1:0]  col_bot,
   input  logic              col_row_end,
   input  logic              col_frame_end,
   output logic              res_we,
   output logic [PIX_W-1:0]  res_pix,
   output logic [IDX_W-1:0]  res_idx
);
   localparam int unsigned GW = sobel_pkg::grad_width(PIX_W);

   generate
      if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
         $error("sobel_pipe: PIX_W must lie in 2..16");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("sobel_pipe: IDX_W must be at least 2");
      end
   endgenerate

   logic [2:0][2:0][PIX_W-1:0] win;
   logic                       win_v, win_last;
   logic signed [GW-1:0]       dx, dy;
   logic                       s1_v, s1_last;
   logic [PIX_W-1:0]           mag;
   logic                       s2_v, s2_last;
   logic [IDX_W-1:0]           cnt;
   logic                       res_last;

   sobel_window #(.PIX_W(PIX_W)) u_win (
      .clk(clk), .rst_n(rst_n), .in_v(col_valid),
      .in_flush(col_row_end | col_frame_end),
      .in_top(col_top), .in_mid(col_mid), .in_bot(col_bot),
      .win(win), .win_v(win_v), .win_last(win_last));

   sobel_grad #(.PIX_W(PIX_W)) u_grad (
      .clk(clk), .rst_n(rst_n), .win(win), .in_v(win_v), .in_last(win_last),
      .dx(dx), .dy(dy), .out_v(s1_v), .out_last(s1_last));

   sobel_mag #(.PIX_W(PIX_W), .MAG_MODE(MAG_MODE)) u_mag (
      .clk(clk), .rst_n(rst_n), .dx(dx), .dy(dy), .in_v(s1_v), .in_last(s1_last),
      .mag(mag), .out_v(s2_v), .out_last(s2_last));

   // Stage three: writeback towards the result cache.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_we   <= 1'b0;
         res_pix  <= '0;
         res_idx  <= '0;
         res_last <= 1'b0;
         cnt      <= '0;
      end else begin
         res_we   <= s2_v;
         res_last <= s2_v && s2_last;
         if (s2_v) begin
            res_pix <= mag;
            res_idx <= cnt;
            cnt     <= s2_last ? '0 : cnt + 1'b1;
         end
      end
   end

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_v |-> ##3 res_we);

   p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !win_v |-> ##3 !res_we);

   p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && !res_last) |=> (!res_we || res_idx == IDX_W'($past(res_idx) + 1'b1)));

   p_idx_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && res_last) |=> (!res_we || res_idx == '0));
endmodule

// File: tb/sobel_pipe_test.sv
module sobel_pipe_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       col_valid = 1'b0;
   logic [7:0] col_top = '0, col_mid = '0, col_bot = '0;
   logic       col_row_end = 1'b0, col_frame_end = 1'b0;
   logic       res_we;
   logic [7:0] res_pix;
   logic [9:0] res_idx;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string phase = "R1";

   // behavioural reference state
   int mw[3][3];          // [column][row]
   int mfill = 0;
   int midx = 0;
   bit exp_we[8];
   int exp_pix[8];
   int exp_idx[8];
   int seed = 7;

   always #10 clk = ~clk;

   sobel_pipe uut (
      .clk(clk), .rst_n(rst_n), .col_valid(col_valid),
      .col_top(col_top), .col_mid(col_mid), .col_bot(col_bot),
      .col_row_end(col_row_end), .col_frame_end(col_frame_end),
      .res_we(res_we), .res_pix(res_pix), .res_idx(res_idx));

   function automatic int nextrand();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 16) & 255;
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // Drive one column (or an idle cycle) and compare outputs against the model.
   task automatic tick(input bit v, input int t, input int m, input int b,
                       input bit re, input bit fe);
      int s, ns, dx, dy, mg;
      @(negedge clk);
      s = cyc % 8;
      checks++;
      if (res_we !== exp_we[s] ||
          (exp_we[s] && (res_pix !== 8'(exp_pix[s]) || res_idx !== 10'(exp_idx[s])))) begin
         errors++;
         $display("FAIL %s cycle %0d: we=%0b pix=%0d idx=%0d expected we=%0b pix=%0d idx=%0d",
                  phase, cyc, res_we, res_pix, res_idx, exp_we[s], exp_pix[s], exp_idx[s]);
      end
      exp_we[s] = 1'b0;
      col_valid = v; col_top = 8'(t); col_mid = 8'(m); col_bot = 8'(b);
      col_row_end = re; col_frame_end = fe;
      if (v) begin
         for (int c = 0; c < 2; c++)
            for (int r = 0; r < 3; r++) mw[c][r] = mw[c+1][r];
         mw[2][0] = t & 255; mw[2][1] = m & 255; mw[2][2] = b & 255;
         if (mfill >= 2) begin
            dx = (mw[2][0] + 2*mw[2][1] + mw[2][2]) - (mw[0][0] + 2*mw[0][1] + mw[0][2]);
            dy = (mw[0][2] + 2*mw[1][2] + mw[2][2]) - (mw[0][0] + 2*mw[1][0] + mw[2][0]);
            mg = iabs(dx) + iabs(dy);
            if (mg > 255) mg = 255;
            ns = (cyc + 4) % 8;
            exp_we[ns] = 1'b1; exp_pix[ns] = mg; exp_idx[ns] = midx;
            midx++;
         end
         if (re || fe) begin mfill = 0; midx = 0; end
         else if (mfill < 3) mfill++;
      end
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin exp_we[i] = 1'b0; exp_pix[i] = 0; exp_idx[i] = 0; end
      for (int c = 0; c < 3; c++) for (int r = 0; r < 3; r++) mw[c][r] = 0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset
      checks++;
      if (res_we !== 1'b0 || res_pix !== 8'd0 || res_idx !== 10'd0) begin
         errors++;
         $display("FAIL R1 reset: we=%0b pix=%0d idx=%0d expected 0 0 0", res_we, res_pix, res_idx);
      end
      rst_n = 1'b1;
      idle(2);  // R1: stays quiet right after reset

      // R3 R5 R6 R8 R9: back-to-back ramp row
      phase = "R3 R5 R6 R8 R9";
      for (int k = 0; k < 10; k++)
         tick(1'b1, k*9, k*13 + 4, k*20 + 1, k == 9, 1'b0);
      idle(5);

      // R2: gaps carrying junk data must not disturb the window
      phase = "R2";
      for (int k = 0; k < 8; k++) begin
         tick(1'b1, 30 + k*3, 60 - k*5, 90 + k, k == 7, 1'b0);
         if (k % 2 == 0) tick(1'b0, 255, 255, 255, 1'b1, 1'b1);
      end
      idle(5);

      // R4: hard edge saturates, soft edge stays linear
      phase = "R4";
      tick(1'b1, 0, 0, 0, 1'b0, 1'b0);
      tick(1'b1, 0, 0, 0, 1'b0, 1'b0);
      tick(1'b1, 255, 255, 255, 1'b0, 1'b0);
      tick(1'b1, 255, 255, 255, 1'b0, 1'b0);
      tick(1'b1, 10, 10, 10, 1'b0, 1'b0);
      tick(1'b1, 10, 10, 10, 1'b0, 1'b0);
      tick(1'b1, 40, 40, 40, 1'b1, 1'b0);
      idle(5);

      // R7 R8 R9: frame end followed at once by a new row (drain overlaps refill)
      phase = "R7 R8 R9";
      for (int k = 0; k < 12; k++)
         tick(1'b1, nextrand(), nextrand(), nextrand(), 1'b0, k == 11);
      for (int k = 0; k < 6; k++)
         tick(1'b1, nextrand(), nextrand(), nextrand(), k == 5, 1'b0);
      for (int k = 0; k < 4; k++)
         tick(1'b1, nextrand(), nextrand(), nextrand(), k == 3, 1'b0);
      idle(5);

      // R6 R10: rows too short to fill the window write nothing
      phase = "R6 R10";
      tick(1'b1, 200, 10, 90, 1'b0, 1'b0);
      tick(1'b1, 5, 250, 17, 1'b1, 1'b0);
      tick(1'b1, 99, 1, 180, 1'b0, 1'b1);
      idle(6);

      // R2 R5 R8: random rows with random gaps
      phase = "R2 R5 R8";
      for (int row = 0; row < 3; row++)
         for (int k = 0; k < 9; k++) begin
            tick(1'b1, nextrand(), nextrand(), nextrand(), k == 8, 1'b0);
            if (nextrand() < 80) tick(1'b0, nextrand(), nextrand(), nextrand(), 1'b0, 1'b0);
         end
      idle(6);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule